// File: doc/BRIEF.md
# Line-Grouping Write Buffer

This block is a first-in first-out store for word writes that sits between a processor and its cache. Each accepted write is tagged, as it enters, with a single continuation bit. The bit says whether the word extends the newest group, which happens when it targets the same cache line as the write accepted just before it, or whether it opens a fresh group. The cache does not drain one word at a time. It sees the complete oldest group at once: a word count plus a flattened window of addresses and data. It removes the whole group with a single take strobe, so that the group can leave as one combined update.

The newest group is held back while it may still grow. A hold timer of HOLD_CYCLES cycles restarts on every accepted write. The oldest group is offered to the cache once any of these is true: a later group exists because a write to another line has arrived, the store is full, or the timer has run out. Once a group has been offered it is frozen, and further writes to the same line open a new group. On the processor side, writes are stalled while the store is full.

Top module: `line_group_wbuf`

## Requirements
- R1: After reset the buffer is empty: wrReady is 1, grpAvail is 0 and grpLen is 0.
- R2: Slot i of grpAddr/grpData (bits i*ADDR_W and i*DATA_W upward) holds the i-th oldest word of the head group, for i below grpLen, with the address and data exactly as written and in arrival order.
- R3: The line of a write is its address with the low log2(LINE_WORDS) bits removed. An accepted write joins the newest group only if its line equals the line of the previously accepted write and that group has not yet been offered. Otherwise it opens a new group. Same-line writes separated by a write to another line never share a group.
- R4: When the head group is the only group and the buffer is not full, grpAvail rises after the HOLD_CYCLES-th rising edge (5 by default) following the group's latest accepted write. Each joining write restarts this count.
- R5: An accepted write that opens a new group makes the older head group available directly after its accepting edge.
- R6: With DEPTH words stored, wrReady is 0 and the head group is offered at once. A write presented while full is ignored and leaves the offered group unchanged.
- R7: grpTake while grpAvail removes all grpLen words of the head group at that single edge. grpLen lies between 1 and DEPTH whenever grpAvail is 1.
- R8: Once grpAvail is 1, grpAvail, grpLen and grpData stay unchanged until the group is taken. A same-line write arriving after that, including one in the same cycle as the take, opens a new group with its own hold time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Processor presents a word write |
| wrAddr | input | ADDR_W | Word address of the write |
| wrData | input | DATA_W | Write data |
| wrReady | output | 1 | Buffer can accept a write (not full) |
| grpAvail | output | 1 | Head group is released to the cache |
| grpTake | input | 1 | Cache consumes the whole head group |
| grpLen | output | $clog2(DEPTH+1) | Number of words in the head group |
| grpAddr | output | DEPTH*ADDR_W | Head group addresses, oldest in slot 0 |
| grpData | output | DEPTH*DATA_W | Head group data, oldest in slot 0 |

## Verification
The assertions check on every cycle that:
- a full buffer always offers its head group;
- an offered group keeps its length and data until it is taken;
- the offered length stays in range;
- a write into an empty buffer is never offered in the next cycle;
- the state after reset is correct.

The exact hold interval, the join-or-split decision for every pattern of line changes, the order of the words inside the window, the write that is ignored while full, and the new group opened by a write that arrives during a take can only be shown by the bench scenarios. Each of them compares the window against a model queue of the accepted words.

// File: rtl/lgwb_pkg.sv
package lgwb_pkg;
  // strobes sent from the control path to the storage path each cycle
  typedef struct packed {
    logic push;       // accept the presented write
    logic pop;        // retire the whole head group
    logic joinBlock;  // newest group already offered: no joining
    logic popNewest;  // the group being retired is also the newest one
  } wbStrobe_t;
endpackage

// File: rtl/lgwb_datapath.sv
module lgwb_datapath
  import lgwb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 16,
  localparam int PTR_W     = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int OFS_W     = $clog2(LINE_WORDS),
  localparam int LINE_W    = ADDR_W - OFS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  wbStrobe_t                strobe,
  input  logic [CNT_W-1:0]         count,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [CNT_W-1:0]         grpLen,
  output logic [DEPTH*ADDR_W-1:0]  grpAddr,
  output logic [DEPTH*DATA_W-1:0]  grpData
);
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0]  contFlag;
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [LINE_W-1:0] lastLine;
  logic              lastValid;
  logic              joinFlag;
  logic [CNT_W-1:0]  lenAcc;

  // continuation bit: same line as the previous accepted write, group still open
  assign joinFlag = lastValid && !strobe.joinBlock &&
                    (wrAddr[ADDR_W-1:OFS_W] == lastLine);

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[wrPtr] <= wrAddr;
      dataMem[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      contFlag  <= '0;
      lastLine  <= '0;
      lastValid <= 1'b0;
    end else begin
      if (strobe.push) begin
        contFlag[wrPtr] <= joinFlag;
        wrPtr           <= wrPtr + PTR_W'(1);
        lastLine        <= wrAddr[ADDR_W-1:OFS_W];
        lastValid       <= 1'b1;
      end else if (strobe.popNewest) begin
        lastValid <= 1'b0;
      end
      if (strobe.pop) begin
        rdPtr <= rdPtr + PTR_W'(lenAcc);
      end
    end
  end

  // length of the head group: leading word plus the run of set continuation bits
  always_comb begin
    logic run;
    lenAcc = (count != '0) ? CNT_W'(1) : '0;
    run    = 1'b1;
    for (int i = 1; i < DEPTH; i++) begin
      if (run && (CNT_W'(i) < count) && contFlag[rdPtr + PTR_W'(i)]) begin
        lenAcc = lenAcc + CNT_W'(1);
      end else begin
        run = 1'b0;
      end
    end
  end

  assign grpLen = lenAcc;

  for (genvar g = 0; g < DEPTH; g++) begin : gWin
    logic [PTR_W-1:0] slot;
    logic             inGroup;
    assign slot    = rdPtr + PTR_W'(g);
    assign inGroup = CNT_W'(g) < lenAcc;
    assign grpAddr[g*ADDR_W +: ADDR_W] = inGroup ? addrMem[slot] : '0;
    assign grpData[g*DATA_W +: DATA_W] = inGroup ? dataMem[slot] : '0;
  end
endmodule

// File: rtl/lgwb_control.sv
module lgwb_control
  import lgwb_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int HOLD_CYCLES = 5,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int HOLD_W     = $clog2(HOLD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrValid,
  input  logic             grpTake,
  input  logic [CNT_W-1:0] grpLen,
  output logic             wrReady,
  output logic             grpAvail,
  output logic [CNT_W-1:0] count,
  output wbStrobe_t        strobe
);
  logic [HOLD_W-1:0] holdCnt;
  logic              full;
  logic              headNewest;

  assign full       = (count == CNT_W'(DEPTH));
  assign headNewest = (grpLen == count);
  assign wrReady    = !full;
  assign grpAvail   = (count != '0) && (!headNewest || full || holdCnt == '0);

  assign strobe.push      = wrValid && !full;
  assign strobe.pop       = grpTake && grpAvail;
  assign strobe.joinBlock = grpAvail && headNewest;
  assign strobe.popNewest = strobe.pop && headNewest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      holdCnt <= '0;
    end else begin
      count <= count + CNT_W'(strobe.push) - (strobe.pop ? grpLen : '0);
      if (strobe.push) begin
        holdCnt <= HOLD_W'(HOLD_CYCLES);
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - HOLD_W'(1);
      end
    end
  end
endmodule

// File: rtl/line_group_wbuf.sv
module line_group_wbuf
  import lgwb_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_WORDS  = 16,
  parameter int HOLD_CYCLES = 5,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrValid,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  output logic                    wrReady,
  output logic                    grpAvail,
  input  logic                    grpTake,
  output logic [CNT_W-1:0]        grpLen,
  output logic [DEPTH*ADDR_W-1:0] grpAddr,
  output logic [DEPTH*DATA_W-1:0] grpData
);
  wbStrobe_t        strobe;
  logic [CNT_W-1:0] count;

  lgwb_control #(.DEPTH(DEPTH), .HOLD_CYCLES(HOLD_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .grpTake(grpTake),
    .grpLen(grpLen), .wrReady(wrReady), .grpAvail(grpAvail),
    .count(count), .strobe(strobe)
  );

  lgwb_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .LINE_WORDS(LINE_WORDS)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .count(count),
    .wrAddr(wrAddr), .wrData(wrData), .grpLen(grpLen),
    .grpAddr(grpAddr), .grpData(grpData)
  );
endmodule

// File: rtl/line_group_wbuf_chk.sv
module line_group_wbuf_chk #(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 32,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wrValid,
  input logic                    wrReady,
  input logic                    grpAvail,
  input logic                    grpTake,
  input logic [CNT_W-1:0]        grpLen,
  input logic [CNT_W-1:0]        count,
  input logic [DEPTH*DATA_W-1:0] grpData
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wrReady && !grpAvail));

  p_hold_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && wrValid) |=> !grpAvail);

  p_full_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrReady |-> grpAvail);

  p_len_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grpAvail |-> (grpLen != '0 && grpLen <= CNT_W'(DEPTH)));

  p_offer_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grpAvail && !grpTake) |=> (grpAvail && $stable(grpLen) && $stable(grpData)));
endmodule

bind line_group_wbuf line_group_wbuf_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrReady(wrReady),
  .grpAvail(grpAvail), .grpTake(grpTake), .grpLen(grpLen),
  .count(count), .grpData(grpData)
);

// File: tb/line_group_wbuf_tb_top.sv
module line_group_wbuf_tb_top;
  localparam int DEPTH = 8;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int LW    = 4;
  localparam int HOLD  = 5;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic grpTake = 1'b0;
  logic wrReady, grpAvail;
  logic [CW-1:0] grpLen;
  logic [DEPTH*AW-1:0] grpAddr;
  logic [DEPTH*DW-1:0] grpData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] dataCtr = 8'h01;
  logic [AW-1:0] qA[$];
  logic [DW-1:0] qD[$];

  always #10 clk = ~clk;

  line_group_wbuf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW),
                    .LINE_WORDS(LW), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrReady(wrReady), .grpAvail(grpAvail),
    .grpTake(grpTake), .grpLen(grpLen), .grpAddr(grpAddr), .grpData(grpData)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a);
    wrValid = 1'b1; wrAddr = a; wrData = dataCtr;
    @(posedge clk); #1;
    wrValid = 1'b0;
    qA.push_back(a); qD.push_back(dataCtr);
    dataCtr = dataCtr + 8'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // R2 window contents against the model queue
  task automatic checkHead(input string tag, input int expLen);
    chk({tag, " R7 grpLen"}, int'(grpLen), expLen);
    for (int i = 0; i < expLen; i++) begin
      chk({tag, " R2 addr"}, int'(grpAddr[i*AW +: AW]), int'(qA[i]));
      chk({tag, " R2 data"}, int'(grpData[i*DW +: DW]), int'(qD[i]));
    end
  endtask

  task automatic takeGroup(input int n);
    grpTake = 1'b1;
    @(posedge clk); #1;
    grpTake = 1'b0;
    repeat (n) begin void'(qA.pop_front()); void'(qD.pop_front()); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..all actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 wrReady", int'(wrReady), 1);
    chk("R1 grpAvail", int'(grpAvail), 0);
    chk("R1 grpLen", int'(grpLen), 0);

    // R4 sweep: n words on one line, gap idle cycles between them
    for (int n = 1; n <= 4; n++) begin
      for (int gap = 0; gap < HOLD; gap++) begin
        logic [5:0] ln;
        ln = 6'((n * 5 + gap) & 63);
        for (int w = 0; w < n; w++) begin
          wr({ln, 2'(w)});
          if (w < n - 1) idle(gap);
        end
        for (int k = 0; k <= HOLD; k++) begin
          if (k > 0) idle(1);
          chk("R4 hold timing", int'(grpAvail), (k == HOLD) ? 1 : 0);
        end
        checkHead("R3 one-line group", n);
        takeGroup(n);
        chk("R7 emptied avail", int'(grpAvail), 0);
        chk("R7 emptied ready", int'(wrReady), 1);
      end
    end

    // R3/R5 sweep: every 4-write pattern over two lines
    for (int p = 0; p < 16; p++) begin
      int runs[4];
      int nRuns;
      bit split;
      nRuns = 0; split = 1'b0;
      for (int i = 0; i < 4; i++) begin
        bit b;
        b = p[i];
        wr(b ? 8'h84 : 8'h40 + 8'(i));
        if (i > 0 && (p[i] != p[i-1])) split = 1'b1;
        chk("R5 offer on line change", int'(grpAvail), int'(split));
        if (i == 0 || p[i] != p[i-1]) begin runs[nRuns] = 1; nRuns++; end
        else runs[nRuns-1]++;
      end
      for (int r = 0; r < nRuns; r++) begin
        int t;
        t = 0;
        while (!grpAvail && t < 20) begin idle(1); t++; end
        chk("R4 eventual offer", int'(grpAvail), 1);
        checkHead("R3 pattern group", runs[r]);
        takeGroup(runs[r]);
      end
      chk("R7 pattern drained", int'(grpAvail), 0);
    end

    // R8 offered group frozen against a later same-line write
    wr(8'h10); wr(8'h11); idle(HOLD);
    chk("R8 offered", int'(grpAvail), 1);
    wr(8'h12);
    chk("R8 still offered", int'(grpAvail), 1);
    checkHead("R8 frozen", 2);
    idle(2);
    checkHead("R8 frozen later", 2);
    takeGroup(2);
    chk("R8 new group held", int'(grpAvail), 0);
    idle(2);
    chk("R8 new group offered", int'(grpAvail), 1);
    checkHead("R8 new group", 1);
    takeGroup(1);

    // R8 same-line write in the same cycle as the take
    wr(8'h20); idle(HOLD);
    chk("R8 offered before take", int'(grpAvail), 1);
    grpTake = 1'b1; wrValid = 1'b1; wrAddr = 8'h21; wrData = dataCtr;
    @(posedge clk); #1;
    grpTake = 1'b0; wrValid = 1'b0;
    void'(qA.pop_front()); void'(qD.pop_front());
    qA.push_back(8'h21); qD.push_back(dataCtr); dataCtr = dataCtr + 8'd1;
    chk("R8 take+write held", int'(grpAvail), 0);
    idle(HOLD - 1);
    chk("R8 take+write still held", int'(grpAvail), 0);
    idle(1);
    chk("R8 take+write offered", int'(grpAvail), 1);
    checkHead("R8 take+write group", 1);
    takeGroup(1);

    // R6 full buffer
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6 ready before full", int'(wrReady), 1);
      wr(8'h30 + 8'(i % LW));
    end
    chk("R6 ready when full", int'(wrReady), 0);
    chk("R6 offered when full", int'(grpAvail), 1);
    checkHead("R6 full group", DEPTH);
    wrValid = 1'b1; wrAddr = 8'hF0; wrData = 8'hEE;
    @(posedge clk); #1;
    wrValid = 1'b0;
    checkHead("R6 write ignored", DEPTH);
    chk("R6 still full", int'(wrReady), 0);
    takeGroup(DEPTH);
    chk("R7 full drained ready", int'(wrReady), 1);
    chk("R7 full drained avail", int'(grpAvail), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule